// File: doc/BRIEF.md
# Edge-Pulse Level Link with Refresh and Silence Watchdog

This block carries one logic level from a sending domain to a receiving one over a channel that can only pass single-cycle pulses, as found across a pulse-coupled isolation barrier. The sender resynchronises its input, detects each change of level and emits a one-cycle pulse on either the "raise" line or the "lower" line. While the input sits still, it repeats the current level with a refresh pulse at a fixed interval, so the far side stays correct at DC even if an earlier pulse was lost.

The receiver is a bistable latch. A raise pulse makes the output high and a lower pulse makes it low, and between pulses the output holds. A silence watchdog counts cycles since the last valid pulse. If that count reaches a timeout, the output is forced to a parameterised default level, because the sender is then presumed dead. Both ends sit in one top module, with the channel brought out as ports so that the integrator can route it, or cut it, between them. Timing is in clock cycles: the refresh interval defaults to 200 cycles and the timeout to 500, and the timeout must be the larger of the two.

Top module: `edge_pulse_link`

## Requirements
- R1: Each change of the synchronised input produces exactly one pulse, one cycle wide, on `tx_raise_o` for a new high level or on `tx_lower_o` for a new low level. The pulse is visible after the third rising clock edge that follows the change of `din`.
- R2: `tx_raise_o` and `tx_lower_o` are never high in the same cycle.
- R3: While the input is steady, the sender repeats the current level (raise for 1, lower for 0) every REFRESH_CYC cycles, counted from the previous pulse of either origin. No other pulse appears in between.
- R4: No pulse is sent while `rst` is high. After `rst` falls, one pulse that carries the `din` level appears after the third rising edge.
- R5: A cycle in which exactly one of `rx_raise_i` or `rx_lower_i` is high sets `dout` to 1 (raise) or 0 (lower) from the next edge on. Without such a pulse, `dout` holds.
- R6: A cycle in which `rx_raise_i` and `rx_lower_i` are both high is ignored: `dout` keeps its value and the silence count is not restarted.
- R7: If no valid pulse arrives for TIMEOUT_CYC cycles after the edge that captured the last one, `dout` becomes DEFAULT_LVL on that edge and stays there until the next valid pulse.
- R8: While `rst` is high, and after it until the first valid pulse, `dout` equals DEFAULT_LVL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ends |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Level to transport (asynchronous to clk) |
| tx_raise_o | output | 1 | Sender pulse line: input went or is high |
| tx_lower_o | output | 1 | Sender pulse line: input went or is low |
| rx_raise_i | input | 1 | Receiver pulse line for a high level |
| rx_lower_i | input | 1 | Receiver pulse line for a low level |
| dout | output | 1 | Reconstructed level |

## Verification
A change on `din` that is driven after a sample shows up as a pulse at the third following sample. A pulse seen on the receiver lines shows up on `dout` at the very next sample. Forcing to default is due TIMEOUT_CYC+1 samples after the last valid pulse was visible. The bench keeps one sample counter that advances once per falling edge, so every expected value is tied to a sample number. It computes the due sample arithmetically from the moments it drove the stimulus, sweeping every phase of an input change against the refresh timer, including changes that coincide with a refresh. At every sample it compares both pulse lines and the output against those computed values.

// File: rtl/epl_pkg.sv
package epl_pkg;

  typedef struct packed {
    logic raise;
    logic lower;
  } pulse_t;

  function automatic pulse_t pulse_for(input logic lvl);
    pulse_t p;
    p.raise = lvl;
    p.lower = ~lvl;
    return p;
  endfunction

  function automatic logic pulse_ok(input pulse_t p);
    return p.raise ^ p.lower;
  endfunction

endpackage

// File: rtl/epl_sync.sv
module epl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/epl_tx.sv
module epl_tx
  import epl_pkg::*;
#(
  parameter int REFRESH_CYC = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   din,
  output pulse_t pulse_o
);
  localparam int TW = $clog2(REFRESH_CYC + 1);
  localparam int WW = $clog2(SYNC_STAGES + 1);

  logic          lvl;
  logic          lvl_q;
  logic [WW-1:0] warm_q;
  logic          armed_q;
  logic [TW-1:0] tmr_q;
  pulse_t        pulse_q;
  logic          warm_done, fire_init, fire_edge, fire_ref, fire;

  epl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (din),
    .q   (lvl)
  );

  assign warm_done = (warm_q == WW'(SYNC_STAGES));
  assign fire_init = warm_done & ~armed_q;
  assign fire_edge = armed_q & (lvl ^ lvl_q);
  assign fire_ref  = armed_q & (tmr_q == TW'(REFRESH_CYC - 1));
  assign fire      = fire_init | fire_edge | fire_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_q  <= '0;
      armed_q <= 1'b0;
      lvl_q   <= 1'b0;
      tmr_q   <= '0;
      pulse_q <= '0;
    end else begin
      lvl_q <= lvl;
      if (!warm_done) warm_q <= warm_q + 1'b1;
      if (fire) begin
        pulse_q <= pulse_for(lvl);
        tmr_q   <= '0;
        armed_q <= 1'b1;
      end else begin
        pulse_q <= '0;
        if (armed_q) tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign pulse_o = pulse_q;

  // Independent gap counter: cycles since the last emitted pulse.
  logic [TW-1:0] gap_q;
  logic          seen_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (pulse_ok(pulse_q)) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != {TW{1'b1}}) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  p_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(pulse_o.raise && pulse_o.lower));

  p_raise_narrow_r1: assert property (@(posedge clk) disable iff (rst)
    pulse_o.raise |=> !pulse_o.raise);

  p_lower_narrow_r1: assert property (@(posedge clk) disable iff (rst)
    pulse_o.lower |=> !pulse_o.lower);

  p_refresh_gap_r3: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (gap_q < TW'(REFRESH_CYC)));
endmodule

// File: rtl/epl_rx.sv
module epl_rx
  import epl_pkg::*;
#(
  parameter int   TIMEOUT_CYC = 500,
  parameter logic DEFAULT_LVL = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  input  pulse_t pulse_i,
  output logic   dout
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          starved_q;
  logic          out_q;
  logic          valid, expire;

  assign valid  = pulse_ok(pulse_i);
  assign expire = ~valid & ~starved_q & (cnt_q == CW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      starved_q <= 1'b1;
      out_q     <= DEFAULT_LVL;
    end else if (valid) begin
      cnt_q     <= '0;
      starved_q <= 1'b0;
      out_q     <= pulse_i.raise;
    end else if (expire) begin
      cnt_q     <= '0;
      starved_q <= 1'b1;
      out_q     <= DEFAULT_LVL;
    end else if (!starved_q) begin
      cnt_q     <= cnt_q + 1'b1;
    end
  end

  assign dout = out_q;

  p_raise_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (pulse_i.raise && !pulse_i.lower) |=> dout);

  p_lower_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (pulse_i.lower && !pulse_i.raise) |=> !dout);

  p_both_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (pulse_i.raise && pulse_i.lower) |=> (dout == $past(dout) || dout == DEFAULT_LVL));

  p_starved_default_r7: assert property (@(posedge clk) disable iff (rst)
    starved_q |-> (dout == DEFAULT_LVL));
endmodule

// File: rtl/edge_pulse_link.sv
module edge_pulse_link
  import epl_pkg::*;
#(
  parameter int   REFRESH_CYC = 200,
  parameter int   TIMEOUT_CYC = 500,
  parameter logic DEFAULT_LVL = 1'b0,
  parameter int   SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic tx_raise_o,
  output logic tx_lower_o,
  input  logic rx_raise_i,
  input  logic rx_lower_i,
  output logic dout
);
  pulse_t tx_p;
  pulse_t rx_p;

  epl_tx #(.REFRESH_CYC(REFRESH_CYC), .SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .pulse_o (tx_p)
  );

  assign tx_raise_o = tx_p.raise;
  assign tx_lower_o = tx_p.lower;
  assign rx_p.raise = rx_raise_i;
  assign rx_p.lower = rx_lower_i;

  epl_rx #(.TIMEOUT_CYC(TIMEOUT_CYC), .DEFAULT_LVL(DEFAULT_LVL)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .pulse_i (rx_p),
    .dout    (dout)
  );

  p_reset_default_r8: assert property (@(posedge clk)
    $past(rst) |-> (dout == DEFAULT_LVL));
endmodule

// File: tb/edge_pulse_link_bench.sv
module edge_pulse_link_bench;
  localparam int RC = 8;
  localparam int TO = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, din, chan_en, inj_r, inj_l;
  logic tx_r, tx_l, dout;
  logic hi_tx_r, hi_tx_l, hi_dout;
  logic rx_r, rx_l;

  assign rx_r = chan_en ? tx_r : inj_r;
  assign rx_l = chan_en ? tx_l : inj_l;

  edge_pulse_link #(.REFRESH_CYC(RC), .TIMEOUT_CYC(TO), .DEFAULT_LVL(1'b0)) u_edge_pulse_link (
    .clk(clk), .rst(rst), .din(din), .tx_raise_o(tx_r), .tx_lower_o(tx_l),
    .rx_raise_i(rx_r), .rx_lower_i(rx_l), .dout(dout));

  edge_pulse_link #(.REFRESH_CYC(RC), .TIMEOUT_CYC(TO), .DEFAULT_LVL(1'b1)) u_dflt_hi (
    .clk(clk), .rst(rst), .din(1'b0), .tx_raise_o(hi_tx_r), .tx_lower_o(hi_tx_l),
    .rx_raise_i(inj_r), .rx_lower_i(inj_l), .dout(hi_dout));

  int t = 0;
  int n_chk = 0;
  int n_bad = 0;
  logic rx_exp;
  logic cur;
  int s;

  task automatic tick();
    @(negedge clk);
    t++;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at sample %0d: actual %b expected %b", req, what, t, act, exp);
    end
  endtask

  // kind: 0 none, 1 raise, 2 lower
  task automatic step_tx(input int kind, input string req);
    tick();
    chk(req, "tx_raise", tx_r, kind == 1);
    chk(req, "tx_lower", tx_l, kind == 2);
    chk("R5", "dout", dout, rx_exp);
    if (kind != 0) rx_exp = (kind == 1);
  endtask

  function automatic int kind_of(input logic lvl);
    return lvl ? 1 : 2;
  endfunction

  task automatic run_dout(input int target, input logic exp, input string req);
    while (t < target) begin
      tick();
      chk(req, "dout", dout, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; din = 1'b1; chan_en = 1'b1; inj_r = 1'b0; inj_l = 1'b0;
    // Reset state (R4, R8)
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4", "tx_raise in reset", tx_r, 1'b0);
      chk("R4", "tx_lower in reset", tx_l, 1'b0);
      chk("R8", "dout in reset", dout, 1'b0);
      chk("R8", "hi dout in reset", hi_dout, 1'b1);
    end
    rst = 1'b0;
    t = 0;
    rx_exp = 1'b0;
    // Initial pulse carrying din=1 at sample 3 (R4); dout default until then (R8)
    step_tx(0, "R4");
    step_tx(0, "R4");
    step_tx(1, "R4");
    s = 3; cur = 1'b1;

    // Phase sweep of input change against refresh timer (R1, R3), both polarities
    for (int rep = 0; rep < 2; rep++) begin
      for (int p = 0; p < RC; p++) begin
        int t0, edge_t, ref_t;
        t0 = s + p;
        while (t < t0) step_tx((t + 1 == s + RC) ? kind_of(cur) : 0, "R3");
        din = ~cur;
        edge_t = t0 + 3;
        ref_t  = s + RC;
        while (t < edge_t) begin
          if (t + 1 == edge_t)                        step_tx(kind_of(~cur), "R1");
          else if (t + 1 == ref_t && ref_t < edge_t)  step_tx(kind_of(cur), "R3");
          else                                        step_tx(0, "R1");
        end
        s = edge_t; cur = ~cur;
      end
    end

    // Back-to-back input changes: one pulse per change, alternating (R1, R2)
    step_tx(0, "R1");
    din = ~cur; step_tx(0, "R1");
    din = cur;  step_tx(0, "R1");
    din = ~cur; step_tx(kind_of(~cur), "R1");
    step_tx(kind_of(cur), "R1");
    step_tx(kind_of(~cur), "R1");
    s = t; cur = ~cur;

    // Steady input: refresh every RC samples (R3)
    while (t < s + 3 * RC) step_tx(((t + 1 - s) % RC == 0) ? kind_of(cur) : 0, "R3");
    s = s + 3 * RC;

    // Make level high, then cut the channel for watchdog (R7)
    if (!cur) begin
      din = 1'b1;
      step_tx(0, "R1"); step_tx(0, "R1"); step_tx(1, "R1");
      s = t; cur = 1'b1;
    end
    tick();
    chk("R5", "dout after raise", dout, 1'b1);
    chan_en = 1'b0;
    run_dout(s + TO, 1'b1, "R7");
    tick();
    chk("R7", "dout forced default", dout, 1'b0);
    run_dout(t + 5, 1'b0, "R7");

    // Recovery by injected raise (R5); double pulse ignored (R6)
    begin
      int u;
      u = t;
      inj_r = 1'b1;
      tick(); inj_r = 1'b0;
      chk("R5", "dout on injected raise", dout, 1'b1);
      run_dout(u + 6, 1'b1, "R5");
      inj_r = 1'b1; inj_l = 1'b1;
      tick(); inj_r = 1'b0; inj_l = 1'b0;
      chk("R6", "dout after double pulse", dout, 1'b1);
      run_dout(u + TO, 1'b1, "R6");
      tick();
      chk("R6", "watchdog not restarted by double pulse", dout, 1'b0);
    end

    // Double pulse while starved leaves default (R6); lower pulse clears (R5)
    inj_r = 1'b1; inj_l = 1'b1;
    tick(); inj_r = 1'b0; inj_l = 1'b0;
    chk("R6", "starved dout after double pulse", dout, 1'b0);
    chk("R6", "hi dout after double pulse", hi_dout, 1'b1);
    inj_r = 1'b1;
    tick(); inj_r = 1'b0;
    chk("R5", "dout raise", dout, 1'b1);
    begin
      int v;
      v = t;
      inj_l = 1'b1;
      tick(); inj_l = 1'b0;
      chk("R5", "dout lower", dout, 1'b0);
      chk("R5", "hi dout lower", hi_dout, 1'b0);
      while (t < v + TO) begin
        tick();
        chk("R7", "hi dout before timeout", hi_dout, 1'b0);
      end
      tick();
      chk("R7", "hi dout forced to high default", hi_dout, 1'b1);
      chk("R7", "dout at low default", dout, 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule